// File: doc/BRIEF.md
# Grid Sensor Change Scorer

This block watches a fixed 4x4 grid of sensors and flags the nodes whose relationship to their neighbours has shifted. Each sample is a vector of sixteen unsigned 12-bit readings. The block keeps the previous vector as a baseline. For every ordered node pair it takes the squared reading difference under the new vector and under the baseline. It squares the change between the two, weights the result by how close the two nodes sit on the grid, and adds the sixteen weighted terms that belong to each node. A node whose total reaches a programmable threshold raises its flag. The flag then stays up until reset.

The datapath handles one pair term per clock, so each scored vector takes 256 cycles. The first vector after reset only sets up the baseline. After each scoring pass, the scored vector becomes the new baseline. All arithmetic is exact unsigned fixed point. The weights carry 16 fraction bits, and the threshold is written in the same scale as the per-node sum.

Top module: `grid_anomaly_detector`

## Requirements
- R1: While reset is low and just after it is released, `flags` is all zero and `done` is low.
- R2: The first accepted `sample_valid` after reset only stores the baseline. No `done` pulse follows and `flags` does not change.
- R3: Node k sits at column k mod 4 and row k div 4. The weight of pair (i,j) is floor(sqrt(floor(2^32 / d^6))), where d is the Euclidean grid distance between the nodes. A node's weight to itself is 0.
- R4: Node k's reading occupies `sample_data[12k+11:12k]`. Node i's score is the sum over j of (dn^2 - do^2)^2 * w(i,j). Here dn is reading i minus reading j in the new vector, and do is the same difference in the baseline. The sum is exact even for readings of 0 and 4095.
- R5: Bit i of `flags` is set when node i's score is greater than or equal to `THRESH`. The default is 655, which is 0.01 scaled by 2^16. A score equal to `THRESH` sets the flag.
- R6: A set flag stays set after later low-scoring vectors and clears only on reset.
- R7: For a scored vector, `done` is high for exactly one cycle. That cycle follows the 256th rising edge after the edge that captured `sample_valid`. The flags are final in that cycle.
- R8: A `sample_valid` that arrives during a scoring pass is ignored. It does not change the timing or the result of the pass, and it does not change the next baseline.
- R9: After each scoring pass, the scored vector becomes the baseline for the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_valid | input | 1 | Strobe, one vector is offered this cycle |
| sample_data | input | 192 | Sixteen 12-bit readings, node k at bits 12k+11..12k |
| flags | output | 16 | Sticky per-node anomaly flags |
| done | output | 1 | One-cycle pulse when a scoring pass completes |

## Verification
Every vector the bench offers is captured on one rising edge. The bench then counts rising edges and samples at the following falling edge. It requires `done` after exactly 256 edges, requires the flags to match in that same half-cycle, and requires `done` to be low again one cycle later. For a baseline-only vector, the bench watches 300 edges and expects no pulse. For the ignored strobe, the bench drives it 100 edges into a pass and still expects the pulse at edge 256. The expected scores use 80-bit arithmetic with weights computed by a separate square-root search. Four copies with different thresholds show the boundary of the comparison: 858 is met exactly, while 859 is missed.

// File: rtl/gad_pkg.sv
package gad_pkg;

   typedef enum logic {ST_IDLE, ST_RUN} gad_state_e;

   // integer square root, floor
   function automatic longint unsigned isqrt64(input longint unsigned v);
      longint unsigned rem;
      longint unsigned res;
      longint unsigned bitv;
      rem  = v;
      res  = 0;
      bitv = 64'd1 << 62;
      while (bitv > rem) bitv = bitv >> 2;
      while (bitv != 0) begin
         if (rem >= res + bitv) begin
            rem = rem - (res + bitv);
            res = (res >> 1) + bitv;
         end else begin
            res = res >> 1;
         end
         bitv = bitv >> 2;
      end
      return res;
   endfunction

   // inverse cube of grid distance, scaled by 2^frac
   function automatic longint unsigned edge_weight(input int adx, input int ady, input int frac);
      longint unsigned d2;
      d2 = longint'(adx * adx + ady * ady);
      if (d2 == 0) return 0;
      return isqrt64((64'd1 << (2 * frac)) / (d2 * d2 * d2));
   endfunction

endpackage

// File: rtl/gad_weight_rom.sv
module gad_weight_rom #(
   parameter int GX    = 4,
   parameter int GY    = 4,
   parameter int WFRAC = 16,
   parameter int WW    = WFRAC + 1,
   parameter int AW    = $clog2(GX * GY)
) (
   input  logic [AW-1:0] addr,
   output logic [WW-1:0] weight
);
   import gad_pkg::*;

   localparam int ENTRIES = GX * GY;

   logic [WW-1:0] tbl [ENTRIES];

   for (genvar ay = 0; ay < GY; ay++) begin : g_row
      for (genvar ax = 0; ax < GX; ax++) begin : g_col
         localparam longint unsigned WV = edge_weight(ax, ay, WFRAC);
         assign tbl[ay * GX + ax] = WW'(WV);
      end
   end

   always_comb begin
      if (int'(addr) < ENTRIES) weight = tbl[addr];
      else                      weight = '0;
   end

endmodule

// File: rtl/gad_pair_term.sv
module gad_pair_term #(
   parameter int DW     = 12,
   parameter int WW     = 17,
   parameter int PROD_W = 4 * DW + WW
) (
   input  logic [DW-1:0]     new_i,
   input  logic [DW-1:0]     new_j,
   input  logic [DW-1:0]     old_i,
   input  logic [DW-1:0]     old_j,
   input  logic [WW-1:0]     weight,
   output logic [PROD_W-1:0] term
);
   localparam int DIFF_W = DW + 1;
   localparam int SQ_W   = 2 * DW;
   localparam int DEL_W  = SQ_W + 1;
   localparam int DD_W   = 2 * SQ_W;

   logic signed [DIFF_W-1:0]   dn, dold;
   logic signed [2*DIFF_W-1:0] pn, pold;
   logic        [SQ_W-1:0]     sqn, sqo;
   logic signed [DEL_W-1:0]    delta;
   logic signed [2*DEL_W-1:0]  dsq;
   logic        [DD_W-1:0]     dd;

   always_comb begin
      dn    = $signed({1'b0, new_i}) - $signed({1'b0, new_j});
      dold  = $signed({1'b0, old_i}) - $signed({1'b0, old_j});
      pn    = dn * dn;
      pold  = dold * dold;
      sqn   = pn[SQ_W-1:0];
      sqo   = pold[SQ_W-1:0];
      delta = $signed({1'b0, sqn}) - $signed({1'b0, sqo});
      dsq   = delta * delta;
      dd    = dsq[DD_W-1:0];
      term  = PROD_W'(dd) * PROD_W'(weight);
   end

endmodule

// File: rtl/grid_anomaly_detector.sv
module grid_anomaly_detector #(
   parameter int              GX     = 4,
   parameter int              GY     = 4,
   parameter int              DW     = 12,
   parameter int              WFRAC  = 16,
   parameter longint unsigned THRESH = 655
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sample_valid,
   input  logic [GX*GY*DW-1:0]   sample_data,
   output logic [GX*GY-1:0]      flags,
   output logic                  done
);
   import gad_pkg::*;

   localparam int NODES  = GX * GY;
   localparam int IDX_W  = $clog2(NODES);
   localparam int AW     = $clog2(NODES);
   localparam int WW     = WFRAC + 1;
   localparam int PROD_W = 4 * DW + WW;
   localparam int ACC_W  = PROD_W + $clog2(NODES);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(NODES - 1);

   if (GX < 2 || GY < 2) begin : g_bad_grid
      $error("grid must be at least 2x2");
   end
   if (WFRAC < 1 || WFRAC > 30) begin : g_bad_frac
      $error("WFRAC out of range 1..30");
   end
   if (DW < 2) begin : g_bad_dw
      $error("DW must be at least 2");
   end

   gad_state_e                    state_q;
   logic                          primed_q;
   logic [IDX_W-1:0]              i_q, j_q;
   logic [ACC_W-1:0]              acc_q, acc_sum;
   logic [NODES-1:0][DW-1:0]      prev_q, cur_q;
   logic [NODES-1:0]              flags_q;
   logic                          done_q;
   logic [AW-1:0]                 rom_addr;
   logic [WW-1:0]                 weight;
   logic [PROD_W-1:0]             term;
   logic                          j_last, i_last;

   // relative grid offset of the current pair selects the weight
   always_comb begin
      int xi, yi, xj, yj, adx, ady;
      xi  = int'(i_q) % GX;
      yi  = int'(i_q) / GX;
      xj  = int'(j_q) % GX;
      yj  = int'(j_q) / GX;
      adx = (xi > xj) ? xi - xj : xj - xi;
      ady = (yi > yj) ? yi - yj : yj - yi;
      rom_addr = AW'(ady * GX + adx);
   end

   gad_weight_rom #(.GX(GX), .GY(GY), .WFRAC(WFRAC), .WW(WW), .AW(AW)) u_rom (
      .addr   (rom_addr),
      .weight (weight)
   );

   gad_pair_term #(.DW(DW), .WW(WW), .PROD_W(PROD_W)) u_term (
      .new_i  (cur_q[i_q]),
      .new_j  (cur_q[j_q]),
      .old_i  (prev_q[i_q]),
      .old_j  (prev_q[j_q]),
      .weight (weight),
      .term   (term)
   );

   assign j_last  = (j_q == LAST);
   assign i_last  = (i_q == LAST);
   assign acc_sum = ((j_q == '0) ? '0 : acc_q) + ACC_W'(term);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         primed_q <= 1'b0;
         i_q      <= '0;
         j_q      <= '0;
         acc_q    <= '0;
         prev_q   <= '0;
         cur_q    <= '0;
         flags_q  <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (sample_valid) begin
                  primed_q <= 1'b1;
                  for (int k = 0; k < NODES; k++) begin
                     if (!primed_q) prev_q[k] <= sample_data[k*DW +: DW];
                     else           cur_q[k]  <= sample_data[k*DW +: DW];
                  end
                  if (primed_q) begin
                     state_q <= ST_RUN;
                     i_q     <= '0;
                     j_q     <= '0;
                  end
               end
            end
            ST_RUN: begin
               acc_q <= acc_sum;
               j_q   <= j_last ? '0 : j_q + 1'b1;
               if (j_last) begin
                  if (acc_sum >= ACC_W'(THRESH)) flags_q[i_q] <= 1'b1;
                  i_q <= i_last ? '0 : i_q + 1'b1;
                  if (i_last) begin
                     prev_q  <= cur_q;
                     state_q <= ST_IDLE;
                     done_q  <= 1'b1;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign flags = flags_q;
   assign done  = done_q;

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   // R7
   done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> ($past(state_q) == ST_RUN && $past(i_q) == LAST && $past(j_q) == LAST));

   // R6
   sticky_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_q & $past(flags_q)) == $past(flags_q));

   // R2
   first_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && !primed_q && sample_valid) |=> (state_q == ST_IDLE && !done_q));

   // R8
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN) |=> $stable(cur_q));

   // R9
   baseline_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (prev_q == $past(cur_q)));

endmodule

// File: tb/grid_anomaly_detector_tb.sv
module grid_anomaly_detector_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int N  = 16;
   localparam int NI = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sample_valid = 1'b0;
   logic [191:0]  sample_data = '0;
   logic [15:0]   fl_a, fl_b, fl_c, fl_d;
   logic          dn_a, dn_b, dn_c, dn_d;

   always #(CLK_PERIOD / 2) clk = ~clk;

   grid_anomaly_detector dut_i (
      .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
      .sample_data(sample_data), .flags(fl_a), .done(dn_a));
   grid_anomaly_detector #(.THRESH(858)) dut_eq (
      .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
      .sample_data(sample_data), .flags(fl_b), .done(dn_b));
   grid_anomaly_detector #(.THRESH(859)) dut_gt (
      .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
      .sample_data(sample_data), .flags(fl_c), .done(dn_c));
   grid_anomaly_detector #(.THRESH(64'd1 << 44)) dut_hi (
      .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
      .sample_data(sample_data), .flags(fl_d), .done(dn_d));

   int unsigned     checks = 0;
   int unsigned     fails  = 0;
   longint unsigned thr [NI] = '{655, 858, 859, 64'd1 << 44};
   longint unsigned wtab [4][4];
   int unsigned     m_prev [N];
   int unsigned     nv [N];
   bit              m_primed;
   logic [15:0]     m_flags [NI];
   int unsigned     seed = 32'h1234_5678;

   function automatic logic [15:0] inst_flags(input int k);
      case (k)
         0: return fl_a;
         1: return fl_b;
         2: return fl_c;
         default: return fl_d;
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int unsigned rnd();
      seed = seed * 32'd1103515245 + 32'd12345;
      return seed >> 8;
   endfunction

   // weights by a plain incremental root search
   task automatic build_weights();
      for (int ax = 0; ax < 4; ax++) begin
         for (int ay = 0; ay < 4; ay++) begin
            longint unsigned d2, q, r;
            d2 = longint'(ax * ax + ay * ay);
            if (d2 == 0) wtab[ax][ay] = 0;
            else begin
               q = (64'd1 << 32) / (d2 * d2 * d2);
               r = 0;
               while ((r + 1) * (r + 1) <= q) r++;
               wtab[ax][ay] = r;
            end
         end
      end
   endtask

   function automatic logic [79:0] model_score(input int i);
      logic [79:0] s;
      s = '0;
      for (int j = 0; j < N; j++) begin
         longint dnw, dol, dl, dd;
         int ax, ay;
         ax  = (i % 4 > j % 4) ? i % 4 - j % 4 : j % 4 - i % 4;
         ay  = (i / 4 > j / 4) ? i / 4 - j / 4 : j / 4 - i / 4;
         dnw = longint'(nv[i]) - longint'(nv[j]);
         dol = longint'(m_prev[i]) - longint'(m_prev[j]);
         dl  = dnw * dnw - dol * dol;
         dd  = dl * dl;
         s   = s + 80'(dd) * 80'(wtab[ax][ay]);
      end
      return s;
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      sample_valid = 1'b0;
      repeat (3) @(negedge clk);
      // R1
      for (int k = 0; k < NI; k++) chk(inst_flags(k) == 16'h0, "R1 flags in reset", 80'(inst_flags(k)), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(dn_a == 1'b0, "R1 done after reset", 80'(dn_a), 0);
      chk(fl_a == 16'h0, "R1 flags after reset", 80'(fl_a), 0);
      m_primed = 1'b0;
      for (int k = 0; k < NI; k++) m_flags[k] = '0;
   endtask

   task automatic step(input bit inject, input string tag);
      int n;
      bit seen;
      logic [191:0] bus;
      for (int k = 0; k < N; k++) bus[k*12 +: 12] = nv[k][11:0];
      @(negedge clk);
      sample_data  = bus;
      sample_valid = 1'b1;
      @(negedge clk);
      sample_valid = 1'b0;
      if (!m_primed) begin
         seen = 1'b0;
         for (int c = 0; c < 300; c++) begin
            @(posedge clk);
            @(negedge clk);
            if (dn_a) seen = 1'b1;
         end
         // R2
         chk(!seen, {"R2 no done for baseline ", tag}, 80'(seen), 0);
         for (int k = 0; k < NI; k++)
            chk(inst_flags(k) == m_flags[k], {"R2 flags unchanged ", tag}, 80'(inst_flags(k)), 80'(m_flags[k]));
         for (int k = 0; k < N; k++) m_prev[k] = nv[k];
         m_primed = 1'b1;
      end else begin
         for (int i = 0; i < N; i++) begin
            logic [79:0] s;
            s = model_score(i);
            for (int k = 0; k < NI; k++) if (s >= 80'(thr[k])) m_flags[k][i] = 1'b1;
         end
         n = 0;
         seen = 1'b0;
         while (!seen && n < 400) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (inject && n == 100) begin
               sample_data  = ~bus;
               sample_valid = 1'b1;
            end
            if (inject && n == 101) begin
               sample_valid = 1'b0;
               sample_data  = bus;
            end
            if (dn_a) seen = 1'b1;
         end
         // R7 timing, R8 unaffected by the busy strobe
         chk(seen && n == 256, {"R7 done latency ", tag}, 80'(n), 256);
         chk(dn_b && dn_c && dn_d, {"R7 done on all copies ", tag}, 80'({dn_b, dn_c, dn_d}), 3'b111);
         // R4 R5 R6 R9
         for (int k = 0; k < NI; k++)
            chk(inst_flags(k) == m_flags[k], {"R4 R5 R6 R9 flags ", tag}, 80'(inst_flags(k)), 80'(m_flags[k]));
         @(negedge clk);
         chk(dn_a == 1'b0, {"R7 one-cycle done ", tag}, 80'(dn_a), 0);
         for (int k = 0; k < N; k++) m_prev[k] = nv[k];
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      build_weights();
      // R3: spot values of the weight formula
      chk(wtab[0][1] == 65536, "R3 unit-distance weight", 80'(wtab[0][1]), 65536);
      chk(wtab[3][3] == 858, "R3 corner weight", 80'(wtab[3][3]), 858);

      do_reset();

      // R2 then identical vector: zero scores
      for (int k = 0; k < N; k++) nv[k] = 0;
      step(1'b0, "zero baseline");
      step(1'b0, "zero repeat");

      // R5 boundary: node 15 scores exactly 858 when node 0 steps by one
      nv[0] = 1;
      step(1'b0, "single step");
      chk(fl_b[15] == 1'b1, "R5 equal to threshold sets", 80'(fl_b[15]), 1);
      chk(fl_c[15] == 1'b0, "R5 one below threshold clear", 80'(fl_c[15]), 0);
      // R6: no change, flags stay
      step(1'b0, "sticky hold");

      // R1 again, fresh baseline, small perturbations
      do_reset();
      for (int k = 0; k < N; k++) nv[k] = 1900 + (rnd() % 200);
      step(1'b0, "random baseline");
      for (int v = 0; v < 6; v++) begin
         for (int p = 0; p < 2; p++) begin
            int unsigned idx;
            idx = rnd() % N;
            nv[idx] = nv[idx] + 1 + (rnd() % 3);
         end
         // R8: strobe injected in the middle of one pass
         step(v == 2, $sformatf("perturb %0d", v));
      end

      // R4 extremes
      do_reset();
      for (int k = 0; k < N; k++) nv[k] = 0;
      step(1'b0, "extreme baseline");
      for (int k = 0; k < N; k++) nv[k] = (k == 0) ? 0 : 4095;
      step(1'b0, "extreme swing");
      for (int k = 0; k < N; k++) nv[k] = (k % 2 == 0) ? 4095 : 0;
      step(1'b1, "extreme alternate");

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule